// File: doc/BRIEF.md
# Segmented Gamma Table Write Port

This block is the register-side loader for a three-part gamma curve. A superfine table covers the very bottom of the input range, a fine table covers the dark region and a coarse table spans the full range. Each point holds a red, green and blue value of 16 bits. Software writes the tables through a plain bus made of a write strobe, a 3-bit register select and a 32-bit data word. Three per-channel limit registers supply the output used for inputs at or above full scale.

A colour point is too wide for one bus word, so it is sent as two consecutive writes to a data register. The first write carries the upper bits of each channel and is only held. The second write carries the lower bits and stores the point. The superfine table has its own index and data registers. The fine and coarse tables share a second pair, whose single position counter runs through the fine points and then the coarse points. A synchronous readback port returns any stored point one cycle after it is addressed. A sticky flag records any point that was dropped because its position lay past the end of its table.

The bus is a control interface, not a stream. It has no back-pressure: every strobed write is taken in the cycle it is presented.

Top module: `gamma_lut_wport`

## Requirements
- R1: After reset every table point reads zero, the three limit outputs are zero, `overflow` is 0, and both index registers are at position 0 with auto-increment off.
- R2: A point is sent as two writes to a data register. The first carries bits [15:6] of red, green and blue in bus bits [29:20], [19:10] and [9:0]. The second carries bits [5:0] of red, green and blue in bus bits [29:24], [19:14] and [5:0]. The table does not change until the second write.
- R3: An index write with bus bit 31 set enables auto-increment. The index then advances by one after each complete two-word point.
- R4: An index write with bus bit 31 clear holds the index, so repeated points overwrite the same location.
- R5: Any index write throws away a half-sent point, and the next data write is taken as a first word.
- R6: The superfine table (9 points) is loaded only through select 0 (index, position in bits [3:0]) and select 1 (data). Its positions 0 to 8 map directly to points 0 to 8.
- R7: The shared pair is select 2 (index, position in bits [9:0]) and select 3 (data). Positions 0 to 255 store fine points 1 to 256, and fine point 0 is never written, so it stays zero.
- R8: Shared positions 256 to 512 store coarse points 0 to 256. Coarse points 0 and 1 are stored like any other point.
- R9: A point whose position is past the last point of its table (superfine above 8, shared above 512) changes no table. It sets `overflow`, which stays at 1 until reset.
- R10: Selects 4, 5 and 6 load bus bits [15:0] into the red, green and blue limit outputs. Each write changes only its own output.
- R11: Readback: the point selected by `rd_tbl` (0 superfine, 1 fine, 2 coarse) and `rd_pt` appears on `rd_data` as {red, green, blue} one clock later. An unused `rd_tbl` code returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Register write word |
| rd_tbl | input | 2 | Readback table select |
| rd_pt | input | 9 | Readback point number |
| rd_data | output | 48 | Readback point {red, green, blue} |
| max_r | output | 16 | Red limit value |
| max_g | output | 16 | Green limit value |
| max_b | output | 16 | Blue limit value |
| overflow | output | 1 | Sticky out-of-range point flag |

## Verification
A table point changes on the same clock edge that takes the second data word, and the index moves on that same edge. Readback adds one register, so a point addressed in cycle N is checked in cycle N+1. The limit outputs and `overflow` are valid right after the edge that takes their write. The bench drives inputs on falling edges. Each readback is queued on the scoreboard with the cycle it is due in, and the monitor compares it just after the falling edge of exactly that cycle. Checks that should show no change, such as a half-sent point or a dropped point, read the location through the same port before the next stimulus.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  localparam int unsigned CH_W   = 16;
  localparam int unsigned HI_W   = 10;
  localparam int unsigned LO_W   = CH_W - HI_W;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned INC_BIT = 31;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb48_t;

  typedef enum logic [2:0] {
    REG_SF_IDX = 3'd0,
    REG_SF_DAT = 3'd1,
    REG_MN_IDX = 3'd2,
    REG_MN_DAT = 3'd3,
    REG_MAX_R  = 3'd4,
    REG_MAX_G  = 3'd5,
    REG_MAX_B  = 3'd6
  } reg_sel_e;

  localparam int unsigned N_TBL = 3;
endpackage

// File: rtl/gamma_word_pair.sv
module gamma_word_pair
  import gamma_lut_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             word_wr,
  input  logic [BUS_W-1:0] word,
  output logic             commit,
  output rgb48_t           entry
);
  logic            half_q;
  logic [HI_W-1:0] r_hi_q, g_hi_q, b_hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      r_hi_q <= '0;
      g_hi_q <= '0;
      b_hi_q <= '0;
    end else if (restart) begin
      half_q <= 1'b0;
    end else if (word_wr) begin
      if (!half_q) begin
        r_hi_q <= word[29:20];
        g_hi_q <= word[19:10];
        b_hi_q <= word[9:0];
        half_q <= 1'b1;
      end else begin
        half_q <= 1'b0;
      end
    end
  end

  // the second word completes the point in the cycle it arrives
  assign commit  = word_wr && half_q && !restart;
  assign entry.r = {r_hi_q, word[29:24]};
  assign entry.g = {g_hi_q, word[19:14]};
  assign entry.b = {b_hi_q, word[5:0]};
endmodule

// File: rtl/gamma_index_ctl.sv
module gamma_index_ctl #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned LAST  = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             load_inc,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             in_range,
  output logic             ovf_evt
);
  localparam logic [IDX_W-1:0] LAST_V = IDX_W'(LAST);

  logic inc_q;

  assign in_range = (idx <= LAST_V);
  assign ovf_evt  = step && !in_range;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      inc_q <= 1'b0;
    end else if (load) begin
      idx   <= load_val;
      inc_q <= load_inc;
    end else if (step && inc_q && in_range) begin
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/gamma_seg_table.sv
module gamma_seg_table
  import gamma_lut_pkg::*;
#(
  parameter int unsigned DEPTH = 257,
  parameter int unsigned AW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  rgb48_t        wdata,
  input  logic [AW-1:0] raddr,
  output rgb48_t        rdata
);
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

  rgb48_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && ({1'b0, waddr} < DEPTH_V)) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = ({1'b0, raddr} < DEPTH_V) ? mem[raddr] : '0;
endmodule

// File: rtl/gamma_lut_wport.sv
module gamma_lut_wport
  import gamma_lut_pkg::*;
#(
  parameter int unsigned SF_PTS     = 9,
  parameter int unsigned FINE_PTS   = 257,
  parameter int unsigned COARSE_PTS = 257,
  parameter int unsigned SF_IW      = 4,
  parameter int unsigned MN_IW      = 10,
  parameter int unsigned PT_AW      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [1:0]       rd_tbl,
  input  logic [PT_AW-1:0] rd_pt,
  output logic [47:0]      rd_data,
  output logic [CH_W-1:0]  max_r,
  output logic [CH_W-1:0]  max_g,
  output logic [CH_W-1:0]  max_b,
  output logic             overflow
);
  localparam int unsigned FINE_SPAN = FINE_PTS - 1;
  localparam int unsigned MN_LAST   = FINE_SPAN + COARSE_PTS - 1;
  localparam int unsigned SF_LAST   = SF_PTS - 1;
  localparam logic [MN_IW-1:0] SPAN_V = MN_IW'(FINE_SPAN);

  // register decode
  logic sf_idx_wr, sf_dat_wr, mn_idx_wr, mn_dat_wr;
  assign sf_idx_wr = wr_en && (wr_addr == REG_SF_IDX);
  assign sf_dat_wr = wr_en && (wr_addr == REG_SF_DAT);
  assign mn_idx_wr = wr_en && (wr_addr == REG_MN_IDX);
  assign mn_dat_wr = wr_en && (wr_addr == REG_MN_DAT);

  // superfine port
  logic             sf_commit, sf_in_range, sf_ovf;
  rgb48_t           sf_entry;
  logic [SF_IW-1:0] sf_idx;

  gamma_word_pair u_sf_pair (
    .clk(clk), .rst_n(rst_n), .restart(sf_idx_wr), .word_wr(sf_dat_wr),
    .word(wr_data), .commit(sf_commit), .entry(sf_entry)
  );

  gamma_index_ctl #(.IDX_W(SF_IW), .LAST(SF_LAST)) u_sf_idx (
    .clk(clk), .rst_n(rst_n), .load(sf_idx_wr), .load_val(wr_data[SF_IW-1:0]),
    .load_inc(wr_data[INC_BIT]), .step(sf_commit), .idx(sf_idx),
    .in_range(sf_in_range), .ovf_evt(sf_ovf)
  );

  // shared fine/coarse port
  logic             mn_commit, mn_in_range, mn_ovf;
  rgb48_t           mn_entry;
  logic [MN_IW-1:0] mn_idx;

  gamma_word_pair u_mn_pair (
    .clk(clk), .rst_n(rst_n), .restart(mn_idx_wr), .word_wr(mn_dat_wr),
    .word(wr_data), .commit(mn_commit), .entry(mn_entry)
  );

  gamma_index_ctl #(.IDX_W(MN_IW), .LAST(MN_LAST)) u_mn_idx (
    .clk(clk), .rst_n(rst_n), .load(mn_idx_wr), .load_val(wr_data[MN_IW-1:0]),
    .load_inc(wr_data[INC_BIT]), .step(mn_commit), .idx(mn_idx),
    .in_range(mn_in_range), .ovf_evt(mn_ovf)
  );

  // table write routing
  logic   [N_TBL-1:0] tbl_we;
  logic   [PT_AW-1:0] tbl_waddr [N_TBL];
  rgb48_t             tbl_wdata [N_TBL];
  rgb48_t             tbl_rdata [N_TBL];
  logic               mn_in_fine;

  assign mn_in_fine   = (mn_idx < SPAN_V);
  assign tbl_we[0]    = sf_commit && sf_in_range;
  assign tbl_waddr[0] = PT_AW'(sf_idx);
  assign tbl_wdata[0] = sf_entry;
  // fine point 0 is skipped: shared position p lands on fine point p+1
  assign tbl_we[1]    = mn_commit && mn_in_fine;
  assign tbl_waddr[1] = PT_AW'(mn_idx + 1'b1);
  assign tbl_wdata[1] = mn_entry;
  assign tbl_we[2]    = mn_commit && !mn_in_fine && mn_in_range;
  assign tbl_waddr[2] = PT_AW'(mn_idx - SPAN_V);
  assign tbl_wdata[2] = mn_entry;

  for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
    localparam int unsigned DEPTH = (t == 0) ? SF_PTS : ((t == 1) ? FINE_PTS : COARSE_PTS);
    gamma_seg_table #(.DEPTH(DEPTH), .AW(PT_AW)) u_tbl (
      .clk(clk), .rst_n(rst_n), .we(tbl_we[t]), .waddr(tbl_waddr[t]),
      .wdata(tbl_wdata[t]), .raddr(rd_pt), .rdata(tbl_rdata[t])
    );
  end

  // readback register
  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_tbl < 2'(N_TBL)) rd_data <= tbl_rdata[rd_tbl];
    else rd_data <= '0;
  end

  // limit registers and sticky flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      max_r    <= '0;
      max_g    <= '0;
      max_b    <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_en && wr_addr == REG_MAX_R) max_r <= wr_data[CH_W-1:0];
      if (wr_en && wr_addr == REG_MAX_G) max_g <= wr_data[CH_W-1:0];
      if (wr_en && wr_addr == REG_MAX_B) max_b <= wr_data[CH_W-1:0];
      if (sf_ovf || mn_ovf) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/gamma_lut_wport_chk.sv
module gamma_lut_wport_chk
  import gamma_lut_pkg::*;
#(
  parameter int unsigned PT_AW = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [CH_W-1:0]  max_r,
  input logic             overflow,
  input logic [2:0]       tbl_we,
  input logic [PT_AW-1:0] fine_waddr,
  input logic             drop_evt
);
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R9
  AST_OVF_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(wr_en)); // R9
  AST_DROP_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> (tbl_we == 3'b000)); // R9
  AST_FINE_PT0_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we[1] |-> (fine_waddr != '0)); // R7
  AST_ONE_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tbl_we)); // R6
  AST_STORE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (|tbl_we) |-> (wr_en && (wr_addr == REG_SF_DAT || wr_addr == REG_MN_DAT))); // R2
  AST_MAX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == REG_MAX_R) |=> $stable(max_r)); // R10
endmodule

bind gamma_lut_wport gamma_lut_wport_chk #(.PT_AW(PT_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .max_r(max_r), .overflow(overflow), .tbl_we(tbl_we),
  .fine_waddr(tbl_waddr[1]), .drop_evt(sf_ovf || mn_ovf)
);

// File: tb/gamma_lut_wport_tb.sv
`timescale 1ns/1ps
module gamma_lut_wport_tb;
  import gamma_lut_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_tbl = '0;
  logic [8:0]  rd_pt = '0;
  logic [47:0] rd_data;
  logic [15:0] max_r, max_g, max_b;
  logic        overflow;

  gamma_lut_wport u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_tbl(rd_tbl), .rd_pt(rd_pt), .rd_data(rd_data),
    .max_r(max_r), .max_g(max_g), .max_b(max_b), .overflow(overflow)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    int          due;
    logic [1:0]  tbl;
    int          pt;
    logic [47:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sb[$];

  logic [47:0] m_sf [9];
  logic [47:0] m_fine [257];
  logic [47:0] m_coarse [257];

  function automatic logic [47:0] pat(int t, int i);
    logic [15:0] r, g, b;
    r = 16'(i * 97 + t * 4099 + 1);
    g = 16'((i * 331) ^ (16'hA5A5 + t));
    b = 16'(16'hFFFF - i * 13 - t * 7);
    return {r, g, b};
  endfunction

  function automatic logic [31:0] w_hi(logic [47:0] v);
    return {2'b00, v[47:38], v[31:22], v[15:6]};
  endfunction

  function automatic logic [31:0] w_lo(logic [47:0] v);
    return (32'(v[37:32]) << 24) | (32'(v[21:16]) << 14) | 32'(v[5:0]);
  endfunction

  task automatic chk(logic [63:0] act, logic [63:0] exp, string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // every task is entered at a falling edge and returns at one
  task automatic bus_wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic put_entry(logic [2:0] a, logic [47:0] v);
    bus_wr(a, w_hi(v));
    bus_wr(a, w_lo(v));
  endtask

  task automatic expect_rd(logic [1:0] tbl, int pt, logic [47:0] exp, string tag);
    rd_item_t it;
    rd_tbl = tbl; rd_pt = 9'(pt);
    it.due = cyc + 1; it.tbl = tbl; it.pt = pt; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  // monitor: compares each readback in the cycle it is due
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        rd_item_t it;
        it = sb.pop_front();
        chk(64'(rd_data), 64'(it.exp), $sformatf("%s tbl%0d pt%0d", it.tag, it.tbl, it.pt));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  localparam logic [31:0] INC = 32'h8000_0000;

  initial begin
    for (int i = 0; i < 9; i++) m_sf[i] = '0;
    for (int i = 0; i < 257; i++) begin m_fine[i] = '0; m_coarse[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(64'(overflow), 64'd0, "R1 overflow");
    chk(64'({max_r, max_g, max_b}), 64'd0, "R1 limits");
    expect_rd(2'd0, 0, 48'd0, "R1");
    expect_rd(2'd1, 0, 48'd0, "R1");
    expect_rd(2'd2, 256, 48'd0, "R1");

    // R6 superfine table with auto-increment (R3)
    bus_wr(REG_SF_IDX, INC);
    for (int i = 0; i < 9; i++) begin
      m_sf[i] = pat(1, i);
      put_entry(REG_SF_DAT, m_sf[i]);
    end
    expect_rd(2'd0, 0, m_sf[0], "R6 R11");
    expect_rd(2'd0, 4, m_sf[4], "R6 R3");
    expect_rd(2'd0, 8, m_sf[8], "R6");
    expect_rd(2'd1, 1, 48'd0, "R6 shared untouched");

    // R7 R8 whole shared range
    bus_wr(REG_MN_IDX, INC);
    for (int p = 0; p < 513; p++) begin
      logic [47:0] v;
      v = pat(2, p);
      if (p < 256) m_fine[p + 1] = v; else m_coarse[p - 256] = v;
      put_entry(REG_MN_DAT, v);
    end
    expect_rd(2'd1, 0, 48'd0, "R7 fine pt0");
    expect_rd(2'd1, 1, m_fine[1], "R7");
    expect_rd(2'd1, 128, m_fine[128], "R7");
    expect_rd(2'd1, 256, m_fine[256], "R7");
    expect_rd(2'd2, 0, m_coarse[0], "R8");
    expect_rd(2'd2, 1, m_coarse[1], "R8");
    expect_rd(2'd2, 128, m_coarse[128], "R8");
    expect_rd(2'd2, 256, m_coarse[256], "R8");
    chk(64'(overflow), 64'd0, "R9 no false flag");

    // R2 first word alone does not store
    bus_wr(REG_MN_IDX, 32'd5);
    bus_wr(REG_MN_DAT, w_hi(pat(3, 0)));
    expect_rd(2'd1, 6, m_fine[6], "R2 half");
    bus_wr(REG_MN_DAT, w_lo(pat(3, 0)));
    m_fine[6] = pat(3, 0);
    expect_rd(2'd1, 6, m_fine[6], "R2 full");

    // R4 fixed index overwrites
    bus_wr(REG_MN_IDX, 32'd10);
    put_entry(REG_MN_DAT, pat(4, 0));
    put_entry(REG_MN_DAT, pat(4, 1));
    m_fine[11] = pat(4, 1);
    expect_rd(2'd1, 11, m_fine[11], "R4");
    expect_rd(2'd1, 12, m_fine[12], "R4 neighbour");

    // R5 index write restarts pairing
    bus_wr(REG_MN_IDX, 32'd20);
    bus_wr(REG_MN_DAT, w_hi(pat(5, 9)));
    bus_wr(REG_MN_IDX, 32'd20);
    put_entry(REG_MN_DAT, pat(5, 0));
    m_fine[21] = pat(5, 0);
    expect_rd(2'd1, 21, m_fine[21], "R5");

    // R3 auto-increment from a mid coarse position
    bus_wr(REG_MN_IDX, INC | 32'd300);
    put_entry(REG_MN_DAT, pat(7, 0));
    put_entry(REG_MN_DAT, pat(7, 1));
    m_coarse[44] = pat(7, 0);
    m_coarse[45] = pat(7, 1);
    expect_rd(2'd2, 44, m_coarse[44], "R3");
    expect_rd(2'd2, 45, m_coarse[45], "R3");

    // R10 limit registers
    bus_wr(REG_MAX_R, 32'hDEAD_1234);
    bus_wr(REG_MAX_G, 32'hBEEF_5678);
    bus_wr(REG_MAX_B, 32'h0F0F_9ABC);
    chk(64'(max_r), 64'h1234, "R10 red");
    chk(64'(max_g), 64'h5678, "R10 green");
    chk(64'(max_b), 64'h9ABC, "R10 blue");

    // R9 past the end
    chk(64'(overflow), 64'd0, "R9 before");
    bus_wr(REG_MN_IDX, INC | 32'd512);
    put_entry(REG_MN_DAT, pat(6, 0));
    m_coarse[256] = pat(6, 0);
    chk(64'(overflow), 64'd0, "R9 last point legal");
    put_entry(REG_MN_DAT, pat(6, 1));
    chk(64'(overflow), 64'd1, "R9 set");
    expect_rd(2'd2, 256, m_coarse[256], "R9 dropped");
    bus_wr(REG_SF_IDX, 32'd9);
    put_entry(REG_SF_DAT, pat(6, 2));
    expect_rd(2'd0, 8, m_sf[8], "R9 sf dropped");
    bus_wr(REG_MN_IDX, 32'd0);
    put_entry(REG_MN_DAT, pat(6, 3));
    m_fine[1] = pat(6, 3);
    expect_rd(2'd1, 1, m_fine[1], "R9 later write ok");
    chk(64'(overflow), 64'd1, "R9 sticky");

    // R11 unused table code
    expect_rd(2'd3, 0, 48'd0, "R11 unused code");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule